// File: doc/BRIEF.md
# Byte-Serial Accumulator Processor Core

This block is a small 8-bit processor with two accumulators, A and B, which together form a 16-bit pair D with A as the high byte. It runs a fixed set of load, add and store instructions. Operands come in three addressing modes. In immediate mode the operand is held in the instruction itself. In direct mode one operand byte gives an address in page zero. In extended mode two operand bytes give a full 16-bit address.

The core drives a single synchronous byte-wide memory port. It presents an address and, when writing, data and a write strobe. The read data for an address returns in the following cycle. Instructions are executed strictly one bus access per cycle: the opcode fetch, each operand byte fetch, any memory operand read, and any result write. The program counter steps by one for every instruction byte it fetches.

An undefined opcode stops the core, and the halt output stays high until reset. A debug view of A, B, the program counter and the flags lets a testbench observe the architectural state.

Top module: `acc8_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the program counter equals parameter RESET_PC, A, B and all flags are 0, and halted is 0.
- R2: The program counter increments by one for each instruction byte fetched. Instruction lengths are 1 byte for NOP (opcode 0x01), 2 bytes for an 8-bit immediate or any direct instruction, 3 bytes for a D immediate or any extended instruction, and an extended or D-immediate operand is sent high byte first.
- R3: Loads copy the operand into the target. The opcodes are: A immediate 0x86, A direct 0x96, A extended 0xB6, B immediate 0xC6, B direct 0xD6, D immediate 0xCC, D direct 0xDC.
- R4: Adds put target + operand into the target. The opcodes are: A immediate 0x8B, A direct 0x9B, A extended 0xBB, B immediate 0xCB, B direct 0xDB, D immediate 0xC3, D direct 0xD3. The flags view is {N,Z,V,C} in bits 3..0, and an add sets C to the carry out of the target's top bit, V to signed overflow, and N and Z from the result.
- R5: D is A:B with A as the high byte. A 16-bit load or add of D from memory reads the high byte at the effective address and the low byte at the next address.
- R6: Stores write the register to memory. The opcodes are: A direct 0x97, A extended 0xB7, B direct 0xD7, D direct 0xDD. A D store writes A at the effective address and B at the next address, in two consecutive cycles.
- R7: Loads and stores set N and Z from the 8- or 16-bit value moved, clear V and leave C unchanged.
- R8: Cycles per instruction are as follows:
  - 2 for NOP;
  - 3 for an 8-bit immediate or an 8-bit direct store;
  - 4 for a D immediate, an 8-bit direct load or add, a D direct store, or an extended store;
  - 5 for a D direct load or add, or an 8-bit extended load or add.
- R9: Any other opcode raises halted 2 cycles after its fetch begins, with the program counter just past the opcode. After that the core writes no memory and its state never changes until reset.
- R10: A direct-mode address is 0x00 followed by the operand byte, so it always falls in page zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rdata | input | 8 | Read data for the address presented one cycle earlier |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe for the current address |
| halted | output | 1 | High once an undefined opcode has been decoded |
| dbg_a | output | 8 | Accumulator A |
| dbg_b | output | 8 | Accumulator B |
| dbg_pc | output | 16 | Program counter |
| dbg_flags | output | 4 | Flags {N,Z,V,C} |

## Verification
The hardest condition to reach from the ports is a 16-bit add whose low-byte carry has to ripple into the high byte, with the sum then stored across two page-zero bytes. The only way to get there is a specific chain of loads, adds and a D store. Directed programs build that chain and also the 8-bit signed-overflow case. Random programs mix every opcode, addressing mode and operand in arbitrary order and end on a random undefined opcode. A bench instruction model then predicts the registers, flags, program counter, cycle count and both data regions of memory.

// File: rtl/acc8_core.sv
module acc8_core #(
  parameter logic [15:0] RESET_PC = 16'h0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        halted,
  output logic [7:0]  dbg_a,
  output logic [7:0]  dbg_b,
  output logic [15:0] dbg_pc,
  output logic [3:0]  dbg_flags
);
  localparam logic [1:0] K_LD = 2'd0, K_ADD = 2'd1, K_ST = 2'd2;
  localparam logic [1:0] R_A = 2'd0, R_B = 2'd1, R_D = 2'd2;
  localparam logic [1:0] M_IMM = 2'd0, M_DIR = 2'd1, M_EXT = 2'd2;
  localparam logic [7:0] OP_NOP = 8'h01;

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_OP1, S_OP2, S_MEM1, S_MEM2, S_WR2, S_HALT} state_t;

  function automatic logic [6:0] decode(input logic [7:0] o);
    case (o)
      8'h86: decode = {1'b1, K_LD,  R_A, M_IMM};
      8'h96: decode = {1'b1, K_LD,  R_A, M_DIR};
      8'hB6: decode = {1'b1, K_LD,  R_A, M_EXT};
      8'hC6: decode = {1'b1, K_LD,  R_B, M_IMM};
      8'hD6: decode = {1'b1, K_LD,  R_B, M_DIR};
      8'hCC: decode = {1'b1, K_LD,  R_D, M_IMM};
      8'hDC: decode = {1'b1, K_LD,  R_D, M_DIR};
      8'h8B: decode = {1'b1, K_ADD, R_A, M_IMM};
      8'h9B: decode = {1'b1, K_ADD, R_A, M_DIR};
      8'hBB: decode = {1'b1, K_ADD, R_A, M_EXT};
      8'hCB: decode = {1'b1, K_ADD, R_B, M_IMM};
      8'hDB: decode = {1'b1, K_ADD, R_B, M_DIR};
      8'hC3: decode = {1'b1, K_ADD, R_D, M_IMM};
      8'hD3: decode = {1'b1, K_ADD, R_D, M_DIR};
      8'h97: decode = {1'b1, K_ST,  R_A, M_DIR};
      8'hB7: decode = {1'b1, K_ST,  R_A, M_EXT};
      8'hD7: decode = {1'b1, K_ST,  R_B, M_DIR};
      8'hDD: decode = {1'b1, K_ST,  R_D, M_DIR};
      default: decode = 7'd0;
    endcase
  endfunction

  state_t      st, nxt;
  logic [15:0] pc, ea;
  logic [7:0]  a, b, op, hi;
  logic [3:0]  flg;
  logic        pc_inc, exec, st_flag;

  logic [6:0] dcur;
  logic       ok, wide;
  logic [1:0] kind, rs, md;
  assign dcur = decode(st == S_DEC ? mem_rdata : op);
  assign ok   = dcur[6];
  assign kind = dcur[5:4];
  assign rs   = dcur[3:2];
  assign md   = dcur[1:0];
  assign wide = (rs == R_D);

  logic [15:0] src, opnd, res;
  logic [16:0] sum16;
  logic [8:0]  sum8;
  logic        msb, zero, carry, ovf;

  assign src   = wide ? {a, b} : (rs == R_B) ? {8'h00, b} : {8'h00, a};
  assign opnd  = wide ? {hi, mem_rdata} : {8'h00, mem_rdata};
  assign sum16 = {1'b0, src} + {1'b0, opnd};
  assign sum8  = {1'b0, src[7:0]} + {1'b0, opnd[7:0]};
  assign res   = (kind == K_ADD) ? (wide ? sum16[15:0] : {8'h00, sum8[7:0]})
               : (kind == K_LD) ? opnd : src;
  assign msb   = wide ? res[15] : res[7];
  assign zero  = wide ? (res == 16'd0) : (res[7:0] == 8'd0);
  assign carry = wide ? sum16[16] : sum8[8];
  assign ovf   = wide ? (src[15] == opnd[15]) && (res[15] != src[15])
                      : (src[7] == opnd[7]) && (res[7] != src[7]);

  always_comb begin
    nxt       = st;
    mem_addr  = pc;
    mem_we    = 1'b0;
    mem_wdata = 8'h00;
    pc_inc    = 1'b0;
    exec      = 1'b0;
    st_flag   = 1'b0;
    case (st)
      S_FETCH: begin
        pc_inc = 1'b1;
        nxt    = S_DEC;
      end
      S_DEC: begin
        if (mem_rdata == OP_NOP) nxt = S_FETCH;
        else if (!ok) nxt = S_HALT;
        else begin
          pc_inc = 1'b1;
          nxt    = S_OP1;
        end
      end
      S_OP1: begin
        if (md == M_IMM) begin
          if (wide) begin
            pc_inc = 1'b1;
            nxt    = S_OP2;
          end else begin
            exec = 1'b1;
            nxt  = S_FETCH;
          end
        end else if (md == M_EXT) begin
          pc_inc = 1'b1;
          nxt    = S_OP2;
        end else begin
          mem_addr = {8'h00, mem_rdata};
          if (kind == K_ST) begin
            mem_we    = 1'b1;
            mem_wdata = (rs == R_B) ? b : a;
            st_flag   = 1'b1;
            nxt       = wide ? S_WR2 : S_FETCH;
          end else nxt = S_MEM1;
        end
      end
      S_OP2: begin
        if (md == M_IMM) begin
          exec = 1'b1;
          nxt  = S_FETCH;
        end else begin
          mem_addr = {hi, mem_rdata};
          if (kind == K_ST) begin
            mem_we    = 1'b1;
            mem_wdata = (rs == R_B) ? b : a;
            st_flag   = 1'b1;
            nxt       = wide ? S_WR2 : S_FETCH;
          end else nxt = S_MEM1;
        end
      end
      S_MEM1: begin
        if (wide) begin
          mem_addr = ea + 16'd1;
          nxt      = S_MEM2;
        end else begin
          exec = 1'b1;
          nxt  = S_FETCH;
        end
      end
      S_MEM2: begin
        exec = 1'b1;
        nxt  = S_FETCH;
      end
      S_WR2: begin
        mem_addr  = ea + 16'd1;
        mem_we    = 1'b1;
        mem_wdata = b;
        nxt       = S_FETCH;
      end
      default: nxt = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_FETCH;
      pc  <= RESET_PC;
      a   <= 8'h00;
      b   <= 8'h00;
      op  <= 8'h00;
      hi  <= 8'h00;
      ea  <= 16'h0000;
      flg <= 4'h0;
    end else begin
      st <= nxt;
      if (pc_inc) pc <= pc + 16'd1;
      if (st == S_DEC) op <= mem_rdata;
      if (st == S_OP1 || st == S_MEM1) hi <= mem_rdata;
      if (st == S_OP1 || st == S_OP2) ea <= mem_addr;
      if (exec) begin
        if (rs == R_A) a <= res[7:0];
        else if (rs == R_B) b <= res[7:0];
        else begin
          a <= res[15:8];
          b <= res[7:0];
        end
        flg <= {msb, zero, (kind == K_ADD) ? ovf : 1'b0, (kind == K_ADD) ? carry : flg[0]};
      end else if (st_flag) begin
        flg <= {msb, zero, 1'b0, flg[0]};
      end
    end
  end

  assign halted    = (st == S_HALT);
  assign dbg_a     = a;
  assign dbg_b     = b;
  assign dbg_pc    = pc;
  assign dbg_flags = flg;
endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk #(
  parameter logic [15:0] RESET_PC = 16'h0100
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] mem_addr,
  input logic        mem_we,
  input logic        halted,
  input logic [15:0] dbg_pc
);
  a_r1_reset_pc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dbg_pc == RESET_PC && !halted));

  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rst_n) |-> (dbg_pc == $past(dbg_pc) || dbg_pc == $past(dbg_pc) + 16'd1));

  a_r6_pair_write_order: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && !$rose(rst_n)) |-> (mem_addr == $past(mem_addr) + 16'd1));

  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r9_no_write_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> $stable(dbg_pc));
endmodule

bind acc8_core acc8_core_chk #(.RESET_PC(RESET_PC)) chk_i (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
  .halted(halted), .dbg_pc(dbg_pc)
);

// File: tb/acc8_core_tb_top.sv
module acc8_core_tb_top;
  localparam logic [15:0] START = 16'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        halted;
  logic [7:0]  dbg_a, dbg_b;
  logic [15:0] dbg_pc;
  logic [3:0]  dbg_flags;

  int checks = 0;
  int failures = 0;

  logic [7:0] mem  [0:2047];
  logic [7:0] refm [0:2047];
  logic [7:0] ops  [0:18];

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[10:0]];
  end

  acc8_core #(.RESET_PC(START)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted), .dbg_a(dbg_a),
    .dbg_b(dbg_b), .dbg_pc(dbg_pc), .dbg_flags(dbg_flags)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit bdec(input logic [7:0] o, output int k, output int r, output int m);
    bdec = 1'b1;
    case (o)
      8'h86: begin k = 0; r = 0; m = 0; end
      8'h96: begin k = 0; r = 0; m = 1; end
      8'hB6: begin k = 0; r = 0; m = 2; end
      8'hC6: begin k = 0; r = 1; m = 0; end
      8'hD6: begin k = 0; r = 1; m = 1; end
      8'hCC: begin k = 0; r = 2; m = 0; end
      8'hDC: begin k = 0; r = 2; m = 1; end
      8'h8B: begin k = 1; r = 0; m = 0; end
      8'h9B: begin k = 1; r = 0; m = 1; end
      8'hBB: begin k = 1; r = 0; m = 2; end
      8'hCB: begin k = 1; r = 1; m = 0; end
      8'hDB: begin k = 1; r = 1; m = 1; end
      8'hC3: begin k = 1; r = 2; m = 0; end
      8'hD3: begin k = 1; r = 2; m = 1; end
      8'h97: begin k = 2; r = 0; m = 1; end
      8'hB7: begin k = 2; r = 0; m = 2; end
      8'hD7: begin k = 2; r = 1; m = 1; end
      8'hDD: begin k = 2; r = 2; m = 1; end
      default: begin k = 0; r = 0; m = 0; bdec = 1'b0; end
    endcase
  endfunction

  function automatic logic [7:0] rd(input logic [15:0] ad);
    rd = refm[ad[10:0]];
  endfunction

  task automatic ref_run(output logic [7:0] ra, output logic [7:0] rb, output logic [3:0] rf,
                         output logic [15:0] rpc, output int rc);
    logic [15:0] p, ad, v, src, res;
    logic [16:0] s;
    logic [7:0]  o;
    logic        n, z, vv, c, wide;
    int k, r, m, nb;
    p = START; ra = 0; rb = 0; rf = 0; rc = 0;
    for (int guard = 0; guard < 1000; guard++) begin
      o = rd(p); p = p + 16'd1;
      if (o == 8'h01) begin rc += 2; continue; end
      if (!bdec(o, k, r, m)) begin rc += 2; break; end
      wide = (r == 2);
      nb = (m == 0) ? (wide ? 2 : 1) : m;
      ad = 16'h0000; v = 16'h0000;
      if (m == 0) v = wide ? {rd(p), rd(p + 16'd1)} : {8'h00, rd(p)};
      else if (m == 1) ad = {8'h00, rd(p)};
      else ad = {rd(p), rd(p + 16'd1)};
      p = p + 16'(nb);
      src = wide ? {ra, rb} : (r == 1) ? {8'h00, rb} : {8'h00, ra};
      c = rf[0]; vv = 1'b0;
      if (k == 2) begin
        if (wide) begin
          refm[ad[10:0]] = ra;
          refm[11'(ad + 16'd1)] = rb;
        end else refm[ad[10:0]] = (r == 1) ? rb : ra;
        rc += 2 + nb + (wide ? 1 : 0);
        res = src;
      end else begin
        if (m != 0) v = wide ? {rd(ad), rd(ad + 16'd1)} : {8'h00, rd(ad)};
        rc += 2 + nb + ((m != 0) ? (wide ? 2 : 1) : 0);
        if (k == 0) res = v;
        else if (wide) begin
          s = {1'b0, src} + {1'b0, v};
          res = s[15:0]; c = s[16];
          vv = ((src[15] ^ res[15]) & (v[15] ^ res[15]));
        end else begin
          s = {9'd0, src[7:0]} + {9'd0, v[7:0]};
          res = {8'h00, s[7:0]}; c = s[8];
          vv = ((src[7] ^ res[7]) & (v[7] ^ res[7]));
        end
        if (r == 0) ra = res[7:0];
        else if (r == 1) rb = res[7:0];
        else begin ra = res[15:8]; rb = res[7:0]; end
      end
      n = wide ? res[15] : res[7];
      z = wide ? (res == 16'd0) : (res[7:0] == 8'd0);
      rf = {n, z, vv, c};
    end
    rpc = p;
  endtask

  logic [15:0] wp;
  task automatic put(input logic [7:0] v);
    mem[wp[10:0]] = v;
    refm[wp[10:0]] = v;
    wp = wp + 16'd1;
  endtask

  task automatic fill_random();
    for (int i = 0; i < 2048; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      mem[i] = v;
      refm[i] = v;
    end
    wp = START;
  endtask

  task automatic gen_random(input int n);
    int k, r, m, sel;
    logic [7:0] o;
    fill_random();
    for (int i = 0; i < n; i++) begin
      sel = int'($urandom % 20);
      o = (sel == 19) ? 8'h01 : ops[sel];
      put(o);
      if (o != 8'h01) begin
        void'(bdec(o, k, r, m));
        if (m == 0) begin
          put(8'($urandom));
          if (r == 2) put(8'($urandom));
        end else if (m == 1) begin
          put(8'h80 + 8'($urandom % 127));
        end else begin
          put(8'h07);
          put(8'($urandom % 255));
        end
      end
    end
    do o = 8'($urandom); while (o == 8'h01 || bdec(o, k, r, m));
    put(o);
  endtask

  int cyc;
  task automatic run_dut();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 5000) begin
      @(posedge clk);
      cyc++;
      #1;
    end
    if (!halted) begin
      failures++;
      checks++;
      $display("FAIL R9 core did not halt actual=0 expected=1");
    end
  endtask

  task automatic compare_all(input string name);
    logic [7:0] ea_, eb_;
    logic [3:0] ef;
    logic [15:0] epc, hpc;
    int ec, bad;
    ref_run(ea_, eb_, ef, epc, ec);
    chk({"R3 A ", name}, 32'(dbg_a), 32'(ea_));
    chk({"R4 B ", name}, 32'(dbg_b), 32'(eb_));
    chk({"R7 flags ", name}, 32'(dbg_flags), 32'(ef));
    chk({"R2 pc ", name}, 32'(dbg_pc), 32'(epc));
    chk({"R8 cycles ", name}, 32'(cyc), 32'(ec));
    hpc = dbg_pc;
    repeat (4) @(posedge clk);
    #1;
    chk({"R9 halt held ", name}, {15'd0, halted, dbg_pc}, {15'd0, 1'b1, hpc});
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) bad++;
    for (int i = 1792; i < 2048; i++) if (mem[i] !== refm[i]) bad++;
    chk({"R6 memory ", name}, 32'(bad), 32'd0);
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] tbl [0:18];
    tbl = '{8'h86, 8'h96, 8'hB6, 8'hC6, 8'hD6, 8'hCC, 8'hDC, 8'h8B, 8'h9B, 8'hBB,
            8'hCB, 8'hDB, 8'hC3, 8'hD3, 8'h97, 8'hB7, 8'hD7, 8'hDD, 8'h01};
    for (int i = 0; i < 19; i++) ops[i] = tbl[i];
    void'($urandom(32'h5eed_1234));

    // R1: reset state
    fill_random();
    put(8'h00);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", 32'(dbg_pc), 32'(START));
    chk("R1 reset regs", {20'd0, dbg_a, dbg_b, dbg_flags}, 32'd0);
    chk("R1 reset halted", 32'(halted), 32'd0);

    // R4 directed: 8-bit signed overflow
    fill_random();
    put(8'h86); put(8'h7F); put(8'h8B); put(8'h01); put(8'h00);
    run_dut();
    chk("R4 overflow A", 32'(dbg_a), 32'h80);
    chk("R4 overflow flags", 32'(dbg_flags), 32'b1010);
    chk("R8 overflow cycles", 32'(cyc), 32'd8);
    compare_all("p1");

    // R5 R7 R10 directed: 16-bit carry ripple then split store in page zero
    fill_random();
    put(8'hCC); put(8'hFF); put(8'hFF); put(8'hC3); put(8'h00); put(8'h01);
    put(8'hC6); put(8'h5A); put(8'hDD); put(8'h90); put(8'h00);
    run_dut();
    chk("R5 D value", {16'd0, dbg_a, dbg_b}, 32'h005A);
    chk("R7 store keeps carry", 32'(dbg_flags), 32'b0001);
    chk("R10 page zero hi byte", 32'(mem[11'h090]), 32'h00);
    chk("R5 page zero lo byte", 32'(mem[11'h091]), 32'h5A);
    chk("R2 pc p2", 32'(dbg_pc), 32'h010B);
    chk("R8 cycles p2", 32'(cyc), 32'd17);
    compare_all("p2");

    // R3 R6 directed: extended load/add/store
    fill_random();
    mem[11'h720] = 8'h33; refm[11'h720] = 8'h33;
    put(8'hB6); put(8'h07); put(8'h20);
    put(8'hBB); put(8'h07); put(8'h20);
    put(8'hB7); put(8'h07); put(8'h30);
    put(8'h00);
    run_dut();
    chk("R3 ext A", 32'(dbg_a), 32'h66);
    chk("R6 ext store", 32'(mem[11'h730]), 32'h66);
    chk("R8 cycles p3", 32'(cyc), 32'd16);
    compare_all("p3");

    // R2 R9 directed: NOPs then undefined opcode
    fill_random();
    put(8'h01); put(8'h01); put(8'h00);
    run_dut();
    chk("R2 nop pc", 32'(dbg_pc), 32'h0103);
    chk("R9 nop halt cycles", 32'(cyc), 32'd6);

    for (int t = 0; t < 30; t++) begin
      gen_random(28);
      run_dut();
      compare_all("random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule